// File: doc/BRIEF.md
# Dynamic Bus Sizing Read Sequencer

The sequencer turns one internal read request (a word address plus a mask of wanted bytes) into one or more read cycles on an external 32-bit bus whose byte enables are active low. The width of the addressed device is unknown when a request arrives. The first bus cycle therefore always asks for every wanted byte. With each ready strobe the device reports how wide it is, as a byte-wide flag and a half-word flag. The sequencer keeps only the lanes that report permits and starts another cycle for the bytes still missing. When every wanted byte has arrived it pulses done and holds the assembled word.

A byte is always carried on its natural lane. The byte at offset k of the word travels on bits 8k+7 down to 8k, and it lands in the same position of the assembled word. The size flags are read again on every ready, so a device may change its reported width between two cycles of the same transfer.

The state machine has four states. ST_IDLE (bus quiet) takes the transition *accept* to ST_START when a request with a non-empty mask is present. ST_START drives the cycle strobe for one clock and then takes *launch* to ST_WAIT. ST_WAIT holds the enables until ready arrives. On ready it takes *partial* back to ST_START if bytes remain, or *complete* to ST_FINISH if none remain. ST_FINISH raises done for one clock and takes *retire* to ST_IDLE.

Top module: `dbs_read_seq`

## Requirements
- R1: After reset, bus_be_n is 4'b1111, bus_cyc and rd_done are 0, and rd_data is 0.
- R2: A request with a non-empty mask, sampled in ST_IDLE, produces a one-clock bus_cyc on the following clock. bus_be_n equals the bitwise inverse of the request mask (bit k low means byte k is wanted) and bus_addr equals the request word address.
- R3: The byte at offset k is taken from bus_rdata[8k+7:8k] and placed in rd_data[8k+7:8k]. Bytes not in the request mask read as zero in rd_data.
- R4: If bus_size8 is high at ready, only the lowest-numbered pending byte is captured. A single pending byte k is driven as bus_be_n 1110, 1101, 1011, 0111 for k = 0, 1, 2, 3.
- R5: If bus_size16 alone is high at ready, the pending bytes among lanes 0–1 are captured when any are pending. Otherwise the pending bytes among lanes 2–3 are captured.
- R6: If both size flags are high at ready, the byte-wide rule of R4 applies.
- R7: If neither size flag is high at ready, every pending byte is captured and the transfer completes.
- R8: After a partial capture, the next clock carries a new bus_cyc with the same bus_addr. bus_be_n is low only for the bytes still pending.
- R9: The size flags are re-read at every ready, so one transfer may mix byte, half-word and full captures.
- R10: Ready and the size flags have no effect before the cycle reaches ST_WAIT. The cycle holds its enables for as many clocks as ready stays low.
- R11: rd_done is high for exactly the one clock after the final capturing ready. rd_data holds that word until the next request is accepted.
- R12: Requests that arrive while a transfer is in progress are ignored. A request with an all-zero mask is also ignored.
- R13: An aligned four-byte read from a device that always reports byte width completes in exactly four bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W-2 | Word address of the request |
| req_mask | input | 4 | Wanted bytes, bit k for offset k, active high |
| bus_ready | input | 1 | Device ready, closes the current bus cycle |
| bus_size8 | input | 1 | Device reports byte width at ready |
| bus_size16 | input | 1 | Device reports half-word width at ready |
| bus_rdata | input | 32 | Read data bus |
| bus_addr | output | ADDR_W-2 | Word address of the bus cycle |
| bus_be_n | output | 4 | Byte enables, active low |
| bus_cyc | output | 1 | One-clock strobe opening each bus cycle |
| rd_data | output | 32 | Assembled read word |
| rd_done | output | 1 | One-clock completion pulse |

## Verification
A request sampled on a rising edge opens its first cycle on the next clock. The cycle's ready is sampled at the end of its ST_WAIT clock. Any follow-up cycle strobe, or the done pulse together with the new rd_data, appears on the clock right after that capturing edge. The bench drives all inputs and reads all outputs on falling edges. It checks the follow-up strobe or the done pulse on the first falling edge after each ready. A scoreboard compares each strobe's address and enables, and each done's word, in the order they appear. On lanes the rules do not permit, the device model drives corrupted bytes, and it holds the size flags high while ready is low, so a wrong lane choice or an early sample changes the word.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
    localparam int LANES   = 4;
    localparam int LANE_W  = 8;
    localparam int DATA_W  = LANES * LANE_W;
    localparam int PAIR    = 2;
    localparam int HALVES  = LANES / PAIR;

    typedef logic [LANES-1:0] lane_mask_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT,
        ST_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        SZ_FULL,
        SZ_HALF,
        SZ_BYTE
    } port_size_t;

    // isolate the lowest set bit of a lane mask
    function automatic lane_mask_t lowest_lane(input lane_mask_t m);
        return m & (~m + lane_mask_t'(1));
    endfunction
endpackage

// File: rtl/dbs_lane_pick.sv
module dbs_lane_pick
    import dbs_pkg::*;
(
    input  lane_mask_t pend,
    input  logic       size8,
    input  logic       size16,
    output lane_mask_t take
);
    port_size_t cls;
    lane_mask_t half_sel;
    logic       found;

    // byte flag outranks half-word flag
    always_comb begin
        if (size8)       cls = SZ_BYTE;
        else if (size16) cls = SZ_HALF;
        else             cls = SZ_FULL;
    end

    // first half-word pair that still has a pending byte
    always_comb begin
        half_sel = '0;
        found    = 1'b0;
        for (int h = 0; h < HALVES; h++) begin
            if (!found && (|pend[h*PAIR +: PAIR])) begin
                half_sel[h*PAIR +: PAIR] = '1;
                found                    = 1'b1;
            end
        end
    end

    always_comb begin
        unique case (cls)
            SZ_BYTE: take = lowest_lane(pend);
            SZ_HALF: take = pend & half_sel;
            default: take = pend;
        endcase
    end
endmodule

// File: rtl/dbs_word_build.sv
module dbs_word_build
    import dbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  lane_mask_t        take,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] word
);
    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            logic [LANE_W-1:0] lane_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    lane_q <= '0;
                else if (clear)
                    lane_q <= '0;
                else if (load && take[l])
                    lane_q <= bus_rdata[l*LANE_W +: LANE_W];
            end
            assign word[l*LANE_W +: LANE_W] = lane_q;
        end
    endgenerate
endmodule

// File: rtl/dbs_seq_fsm.sv
module dbs_seq_fsm
    import dbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_go,
    input  logic       bus_ready,
    input  logic       last,
    output seq_state_t state,
    output logic       accept,
    output logic       capture,
    output logic       bus_cyc,
    output logic       rd_done,
    output logic       lanes_on
);
    seq_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:   if (req_go) state_d = ST_START;              // accept
            ST_START:  state_d = ST_WAIT;                           // launch
            ST_WAIT:   if (bus_ready)
                           state_d = last ? ST_FINISH : ST_START;   // complete / partial
            ST_FINISH: state_d = ST_IDLE;                           // retire
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept   = 1'b0;
        capture  = 1'b0;
        bus_cyc  = 1'b0;
        rd_done  = 1'b0;
        lanes_on = 1'b0;
        unique case (state)
            ST_IDLE:   accept = req_go;
            ST_START:  begin bus_cyc = 1'b1; lanes_on = 1'b1; end
            ST_WAIT:   begin capture = bus_ready; lanes_on = 1'b1; end
            ST_FINISH: rd_done = 1'b1;
            default:   ;
        endcase
    end

    assert_cyc_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |=> !bus_cyc);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);
endmodule

// File: rtl/dbs_read_seq.sv
module dbs_read_seq
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:2]   req_addr,
    input  logic [LANES-1:0]    req_mask,
    input  logic                bus_ready,
    input  logic                bus_size8,
    input  logic                bus_size16,
    input  logic [DATA_W-1:0]   bus_rdata,
    output logic [ADDR_W-1:2]   bus_addr,
    output logic [LANES-1:0]    bus_be_n,
    output logic                bus_cyc,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_done
);
    seq_state_t state;
    logic       accept, capture, lanes_on, last, req_go;
    lane_mask_t pend_q, take, remain;
    logic [ADDR_W-1:2] addr_q;

    assign req_go = req_valid && (|req_mask);
    assign remain = pend_q & ~take;
    assign last   = (remain == '0);

    dbs_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_go    (req_go),
        .bus_ready (bus_ready),
        .last      (last),
        .state     (state),
        .accept    (accept),
        .capture   (capture),
        .bus_cyc   (bus_cyc),
        .rd_done   (rd_done),
        .lanes_on  (lanes_on)
    );

    dbs_lane_pick u_pick (
        .pend   (pend_q),
        .size8  (bus_size8),
        .size16 (bus_size16),
        .take   (take)
    );

    dbs_word_build u_build (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .load      (capture),
        .take      (take),
        .bus_rdata (bus_rdata),
        .word      (rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            addr_q <= '0;
        end else if (accept) begin
            pend_q <= req_mask;
            addr_q <= req_addr;
        end else if (capture) begin
            pend_q <= remain;
        end
    end

    assign bus_addr = addr_q;
    assign bus_be_n = lanes_on ? ~pend_q : '1;

    assert_start_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && $past(accept)) |-> (bus_be_n == ~$past(req_mask)));

    assert_byte_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && bus_size8) |-> ($countones(take) == 1));

    assert_half_in_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !bus_size8 && bus_size16) |-> (take[3:2] == '0 || take[1:0] == '0));

    assert_full_finishes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !bus_size8 && !bus_size16) |=> rd_done);

    assert_pend_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> ($countones(pend_q) < $countones($past(pend_q))));

    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !last) |=> (bus_cyc && bus_addr == $past(bus_addr)));

    assert_hold_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !accept) |=> $stable(rd_data));

    assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !$past(accept)) |-> (bus_addr == $past(bus_addr)));
endmodule

// File: tb/dbs_read_seq_test.sv
module dbs_read_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          req_valid = 1'b0;
    logic [AW-1:2] req_addr = '0;
    logic [3:0]    req_mask = '0;
    logic          bus_ready = 1'b0;
    logic          bus_size8 = 1'b0;
    logic          bus_size16 = 1'b0;
    logic [31:0]   bus_rdata = '0;
    logic [AW-1:2] bus_addr;
    logic [3:0]    bus_be_n;
    logic          bus_cyc;
    logic [31:0]   rd_data;
    logic          rd_done;

    dbs_read_seq #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_mask(req_mask), .bus_ready(bus_ready), .bus_size8(bus_size8),
        .bus_size16(bus_size16), .bus_rdata(bus_rdata), .bus_addr(bus_addr),
        .bus_be_n(bus_be_n), .bus_cyc(bus_cyc), .rd_data(rd_data), .rd_done(rd_done)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc_cnt = 0;

    logic [1:0]    scr [0:7];
    int            scr_idx = 0;
    int            wait_set = 0;
    int            wcnt = 0;
    logic          in_wait = 1'b0;
    logic [3:0]    m_pend = '0;
    logic [3:0]    m_take = '0;
    logic [AW-1:2] cur_addr = '0;
    bit            done_seen = 1'b0;
    logic          prev_done = 1'b0;

    logic [AW+1:0] cyc_q [$];
    string         tag_q [$];
    logic [31:0]   data_q [$];

    function automatic logic [31:0] dev_word(input logic [AW-1:2] a);
        return {a[9:2] ^ 8'h3C, a[9:2] + 8'h51, ~a[9:2], a[9:2] ^ 8'hC7};
    endfunction

    // sz = {half-word flag, byte flag}
    function automatic logic [3:0] model_take(input logic [3:0] p, input logic [1:0] sz);
        if (sz[0])      return p & (~p + 4'd1);
        else if (sz[1]) return (p[1:0] != 2'b00) ? (p & 4'b0011) : (p & 4'b1100);
        else            return p;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // device model
    always @(negedge clk) begin
        if (bus_ready) begin
            m_pend = m_pend & ~m_take;
            scr_idx++;
            bus_ready = 1'b0;
            in_wait = 1'b0;
            if (m_pend != 4'b0)
                chk(bus_cyc == 1'b1, "R8 restart strobe next clock", 64'(bus_cyc), 64'd1);
            else
                chk(rd_done == 1'b1, "R11 done next clock after last ready", 64'(rd_done), 64'd1);
        end
        if (bus_cyc) begin
            in_wait = 1'b1;
            wcnt = wait_set;
            bus_size8 = 1'b1;
            bus_size16 = 1'b1;
        end else if (in_wait) begin
            if (wcnt > 0) begin
                wcnt--;
                bus_size8 = 1'b1;   // noise while not ready (R10)
                bus_size16 = 1'b1;
                bus_rdata = 32'hDEAD_BEEF;
            end else begin
                logic [1:0]  sz;
                logic [31:0] w;
                sz = scr[scr_idx];
                bus_size8 = sz[0];
                bus_size16 = sz[1];
                m_take = model_take(m_pend, sz);
                w = dev_word(cur_addr);
                for (int l = 0; l < 4; l++)
                    bus_rdata[l*8 +: 8] = m_take[l] ? w[l*8 +: 8] : (~w[l*8 +: 8] ^ 8'h5A);
                bus_ready = 1'b1;
            end
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_cyc) begin
                if (cyc_q.size() == 0) begin
                    chk(1'b0, "R12 unexpected bus cycle", {34'd0, bus_addr}, 64'd0);
                end else begin
                    logic [AW+1:0] it;
                    string t;
                    it = cyc_q.pop_front();
                    t = tag_q.pop_front();
                    chk({bus_addr, bus_be_n} == it, t, 64'({bus_addr, bus_be_n}), 64'(it));
                end
            end
            if (rd_done) begin
                chk(!prev_done, "R11 single done pulse", 64'(prev_done), 64'd0);
                if (data_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected done", 64'(rd_data), 64'd0);
                end else begin
                    logic [31:0] e;
                    e = data_q.pop_front();
                    chk(rd_data == e, "R3 assembled word", 64'(rd_data), 64'(e));
                end
                done_seen = 1'b1;
            end
            prev_done = rd_done;
        end
    end

    task automatic xfer(input logic [AW-1:2] addr, input logic [3:0] mask,
                        input logic [15:0] s, input int waits, input bit inject, input string tag);
        logic [3:0]  p;
        logic [3:0]  t;
        logic [31:0] w;
        logic [31:0] e;
        int i;
        for (int k = 0; k < 8; k++) scr[k] = s[2*k +: 2];
        p = mask;
        i = 0;
        while (p != 4'b0 && i < 8) begin
            cyc_q.push_back({addr, ~p});
            tag_q.push_back(tag);
            t = model_take(p, scr[i]);
            p = p & ~t;
            i++;
        end
        w = dev_word(addr);
        for (int l = 0; l < 4; l++) e[l*8 +: 8] = mask[l] ? w[l*8 +: 8] : 8'h00;
        data_q.push_back(e);
        scr_idx = 0;
        m_pend = mask;
        cur_addr = addr;
        wait_set = waits;
        done_seen = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_mask = mask;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 200 && !done_seen; k++) begin
            if (inject && (k == 1 || k == 4)) begin
                req_valid = 1'b1; req_addr = ~addr; req_mask = 4'hF;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(done_seen, {tag, " completion"}, 64'(done_seen), 64'd1);
        repeat (3) @(negedge clk);
        chk(rd_data == e, "R11 data held after done", 64'(rd_data), 64'(e));
        chk(cyc_q.size() == 0, "R12 no leftover cycles", 64'(cyc_q.size()), 64'd0);
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 50000) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired actual=%0d expected=<50000", cyc_cnt);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_be_n == 4'hF && !bus_cyc && !rd_done && rd_data == 32'h0,
            "R1 reset state", {27'd0, bus_be_n, bus_cyc, rd_done, rd_data}, {27'd0, 4'hF, 2'b00, 32'h0});
        rst_n = 1'b1;
        @(negedge clk);

        xfer(30'h0000_0040, 4'hF, 16'h0000, 0, 1'b0, "R7 full width single cycle");
        xfer(30'h0000_0041, 4'hF, 16'h0055, 0, 1'b0, "R13 R4 four byte cycles");
        xfer(30'h0000_0042, 4'hF, 16'h00AA, 0, 1'b0, "R5 half-word cycles");
        xfer(30'h0000_0043, 4'hF, 16'h00FF, 0, 1'b0, "R6 byte flag wins");
        xfer(30'h0000_0044, 4'hF, 16'h0006, 0, 1'b0, "R9 mixed sizes");
        xfer(30'h0000_0045, 4'b0110, 16'h000A, 0, 1'b0, "R5 upper half after lower");
        xfer(30'h0000_0046, 4'b1000, 16'h0001, 0, 1'b0, "R4 byte 3 enables");
        xfer(30'h0000_0047, 4'b0101, 16'h0005, 3, 1'b0, "R10 ready wait states");
        xfer(30'h0000_0048, 4'hF, 16'h0055, 1, 1'b1, "R12 busy request ignored");
        xfer(30'h0000_0049, 4'b1100, 16'h0002, 0, 1'b0, "R2 partial mask first cycle");

        @(negedge clk);
        req_valid = 1'b1; req_addr = 30'h0000_0077; req_mask = 4'b0000;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(!bus_cyc && bus_be_n == 4'hF, "R12 empty mask ignored",
            {59'd0, bus_cyc, bus_be_n}, {59'd0, 1'b0, 4'hF});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule